// File: doc/BRIEF.md
# Zero-biased fast-track redundancy voter

This block merges the outputs of several replicated logic modules into a single stage result. The replicas are grouped into modules of unequal redundancy, for example a three-way module next to a non-redundant one. Every replica comes from precharged dynamic logic that rests at 1 and can only fall to 0 when it evaluates. A spurious 0 is therefore rare, and a 0 is also the value that settles fastest. The voter exploits this. It counts zero votes as the replicas report in. As soon as the configured number of zeros has arrived, it commits a 0 and does not wait for slower replicas.

An evaluation starts with a one-cycle start pulse. Each replica then presents its bit together with a valid strobe, at whatever cycle it finishes. The first valid strobe of a replica is captured and later ones are ignored. The result commits either when the zero threshold is met, which sets the early flag, or when every replica has reported with too few zeros, which gives a 1. After a commit the result is frozen until the next start pulse. The module grouping and the zero threshold are parameters. The replica count is derived from the grouping. A threshold outside 1 to the replica count stops elaboration.

Top module: `zfast_voter`

## Requirements
- R1: After reset, and before the first start pulse, done_o=0, result_o=1 and early_o=0, and valid strobes are ignored.
- R2: A start pulse clears all captured votes and any previous commit, so done_o=0 and early_o=0 in the following cycle. Valid strobes in the same cycle as the start pulse are ignored.
- R3: On the clock edge at which the captured zero count reaches the threshold K, the block registers result_o=0, done_o=1 and early_o=1 together, visible in the next cycle. Replicas still outstanding do not delay this. If the K-th zero arrives together with the last replica, the early flag is still set.
- R4: When all replicas have reported and fewer than K of them are zero, the block registers result_o=1, done_o=1 and early_o=0.
- R5: Each replica is captured on its first valid strobe after start. Further strobes from the same replica neither add votes nor change the captured value.
- R6: Zeros from every redundancy group count equally toward K, and zeros that arrive in the same cycle are all counted in that cycle.
- R7: Once done_o=1, result_o and early_o hold their values and further strobes are ignored until the next start pulse.
- R8: While done_o=0, result_o reads 1, which is the precharged value.
- R9: The replica count is the sum of the group sizes. Under the grouping 3,2,1 (six replicas) the block commits a 1 only after all six have reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-evaluation pulse |
| rep_i | input | N_REP | Replica output bits. Group 0 occupies the lowest indices. |
| rep_vld_i | input | N_REP | Per-replica valid strobes |
| result_o | output | 1 | Committed stage result |
| done_o | output | 1 | Result is committed |
| early_o | output | 1 | Commit came from reaching the zero threshold |

## Verification
The bench targets the following mistakes, each with its visible symptom:
- Double counting of a replica that strobes twice would commit 0 too early on a single real zero.
- Missing one of two zeros that arrive in the same cycle would delay the commit by a cycle or lose it.
- Honouring strobes in the start cycle, or after a commit, would change or pre-empt the result.
- Giving the all-reported rule priority over the zero threshold would drop the early flag when the K-th zero is also the last arrival.
- A six-replica build with the grouping 3,2,1 would show a replica count derived wrongly, because it would commit before the last replica reports.

// File: rtl/zv_pkg.sv
`timescale 1ns/1ps
package zv_pkg;
  localparam int unsigned WAY_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DONE} vote_st_e;

  function automatic int unsigned grp_ways(logic [63:0] v, int unsigned g);
    int unsigned w;
    w = int'(v[g*WAY_W +: WAY_W]);
    return w;
  endfunction

  function automatic int unsigned grp_base(logic [63:0] v, int unsigned g);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < g; i++) s += grp_ways(v, i);
    return s;
  endfunction
endpackage

// File: rtl/zv_group.sv
`timescale 1ns/1ps
module zv_group #(
  parameter int unsigned WAYS  = 3,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [WAYS-1:0]  rep_i,
  input  logic [WAYS-1:0]  vld_i,
  output logic [CNT_W-1:0] zcnt_o,
  output logic             all_o
);
  logic [WAYS-1:0] seen_q, zero_q, seen_d, zero_d, new_w;

  always_comb begin
    new_w  = en_i ? (vld_i & ~seen_q) : '0;
    seen_d = seen_q | new_w;
    zero_d = zero_q | (new_w & ~rep_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      zero_q <= '0;
    end else if (clr_i) begin
      seen_q <= '0;
      zero_q <= '0;
    end else begin
      seen_q <= seen_d;
      zero_q <= zero_d;
    end
  end

  // counts include this cycle's arrivals so commit lands on the arrival edge
  assign zcnt_o = CNT_W'($countones(zero_d));
  assign all_o  = &seen_d;
endmodule

// File: rtl/zv_commit.sv
`timescale 1ns/1ps
module zv_commit #(
  parameter int unsigned K     = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] zsum_i,
  input  logic             all_i,
  output logic             en_o,
  output logic             result_o,
  output logic             done_o,
  output logic             early_o
);
  import zv_pkg::*;

  vote_st_e st_q;
  logic     res_q, early_q;
  logic     hit_w;

  assign hit_w = zsum_i >= CNT_W'(K);
  assign en_o  = (st_q == ST_EVAL) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      res_q   <= 1'b1;
      early_q <= 1'b0;
    end else if (start_i) begin
      st_q    <= ST_EVAL;
      res_q   <= 1'b1;
      early_q <= 1'b0;
    end else if (st_q == ST_EVAL) begin
      if (hit_w) begin
        st_q    <= ST_DONE;
        res_q   <= 1'b0;
        early_q <= 1'b1;
      end else if (all_i) begin
        st_q    <= ST_DONE;
        res_q   <= 1'b1;
        early_q <= 1'b0;
      end
    end
  end

  assign result_o = res_q;
  assign done_o   = (st_q == ST_DONE);
  assign early_o  = early_q;
endmodule

// File: rtl/zfast_voter.sv
`timescale 1ns/1ps
module zfast_voter #(
  parameter int unsigned                          NUM_GRP  = 2,
  parameter logic [NUM_GRP*zv_pkg::WAY_W-1:0]     GRP_WAYS = {4'd1, 4'd3},
  parameter int unsigned                          K_ZERO   = 2,
  parameter int unsigned                          N_REP    = zv_pkg::grp_base(64'(GRP_WAYS), NUM_GRP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_REP-1:0] rep_i,
  input  logic [N_REP-1:0] rep_vld_i,
  output logic             result_o,
  output logic             done_o,
  output logic             early_o
);
  localparam int unsigned CNT_W = $clog2(N_REP + 1);
  localparam logic [63:0] WAYS_V = 64'(GRP_WAYS);

  if (K_ZERO < 1 || K_ZERO > N_REP) begin : g_bad_k
    $error("zfast_voter: K_ZERO out of range");
  end
  if (N_REP != zv_pkg::grp_base(WAYS_V, NUM_GRP)) begin : g_bad_n
    $error("zfast_voter: N_REP does not match grouping");
  end

  logic [CNT_W-1:0]   gz   [NUM_GRP];
  logic [NUM_GRP-1:0] gall;
  logic [CNT_W-1:0]   zsum;
  logic               en;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned W = zv_pkg::grp_ways(WAYS_V, g);
    localparam int unsigned B = zv_pkg::grp_base(WAYS_V, g);
    zv_group #(.WAYS(W), .CNT_W(CNT_W)) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_i),
      .en_i   (en),
      .rep_i  (rep_i[B +: W]),
      .vld_i  (rep_vld_i[B +: W]),
      .zcnt_o (gz[g]),
      .all_o  (gall[g])
    );
  end

  always_comb begin
    zsum = '0;
    for (int unsigned g = 0; g < NUM_GRP; g++) zsum = zsum + gz[g];
  end

  zv_commit #(.K(K_ZERO), .CNT_W(CNT_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .zsum_i   (zsum),
    .all_i    (&gall),
    .en_o     (en),
    .result_o (result_o),
    .done_o   (done_o),
    .early_o  (early_o)
  );
endmodule

// File: rtl/zv_voter_chk.sv
`timescale 1ns/1ps
module zv_voter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic result_o,
  input logic done_o,
  input logic early_o
);
  assert_early_is_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> (done_o && !result_o));

  assert_late_is_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !early_o) |-> result_o);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !early_o));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(result_o) && $stable(early_o)));

  assert_precharge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> result_o);
endmodule

bind zfast_voter zv_voter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .result_o (result_o),
  .done_o   (done_o),
  .early_o  (early_o)
);

// File: tb/tb_zfast_voter.sv
`timescale 1ns/1ps
module tb_zfast_voter;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  int errs = 0;
  int checks = 0;

  // 4-replica build: replicas 0..2 three-way group, 3 non-redundant, K=2
  logic       start = 1'b0;
  logic [3:0] rep = '1, vld = '0;
  logic       res, done, early;

  zfast_voter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .rep_i(rep), .rep_vld_i(vld),
    .result_o(res), .done_o(done), .early_o(early)
  );

  // 6-replica build: groups 3,2,1, K=3
  logic       start6 = 1'b0;
  logic [5:0] rep6 = '1, vld6 = '0;
  logic       res6, done6, early6;

  zfast_voter #(.NUM_GRP(3), .GRP_WAYS({4'd1, 4'd2, 4'd3}), .K_ZERO(3)) dut6 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start6),
    .rep_i(rep6), .rep_vld_i(vld6),
    .result_o(res6), .done_o(done6), .early_o(early6)
  );

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: {result,done,early} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic go();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic put(logic [3:0] v, logic [3:0] b);
    rep = b; vld = v; tick(); vld = '0; rep = '1;
  endtask

  task automatic go6();
    start6 = 1'b1; tick(); start6 = 1'b0;
  endtask

  task automatic put6(logic [5:0] v, logic [5:0] b);
    rep6 = b; vld6 = v; tick(); vld6 = '0; rep6 = '1;
  endtask

  task automatic t_reset();
    chk("R1 reset", {res, done, early}, 3'b100);
    put(4'b1111, 4'b0000);
    chk("R1 strobes before start", {res, done, early}, 3'b100);
  endtask

  task automatic t_fast_zero();
    go();
    chk("R2 after start", {res, done, early}, 3'b100);
    put(4'b1000, 4'b0000);
    chk("R8 one zero pending", {res, done, early}, 3'b100);
    put(4'b0001, 4'b0000);
    chk("R3 second zero commits", {res, done, early}, 3'b011);
  endtask

  task automatic t_all_ones();
    go();
    put(4'b1111, 4'b1111);
    chk("R4 all ones together", {res, done, early}, 3'b110);
  endtask

  task automatic t_stagger_one_zero();
    go();
    put(4'b0010, 4'b0000);
    chk("R8 single zero", {res, done, early}, 3'b100);
    put(4'b0101, 4'b1111);
    chk("R4 three reported", {res, done, early}, 3'b100);
    put(4'b1000, 4'b1111);
    chk("R4 last arrival one", {res, done, early}, 3'b110);
  endtask

  task automatic t_repeat_strobe();
    go();
    put(4'b0001, 4'b0000);
    put(4'b0001, 4'b0000);
    chk("R5 repeat zero not recounted", {res, done, early}, 3'b100);
    put(4'b1110, 4'b1111);
    chk("R5 commit one after all", {res, done, early}, 3'b110);
    go();
    put(4'b0001, 4'b1111);
    put(4'b0001, 4'b0000);
    put(4'b1000, 4'b0000);
    chk("R5 first value kept", {res, done, early}, 3'b100);
  endtask

  task automatic t_same_cycle_and_hold();
    go();
    put(4'b1001, 4'b0000);
    chk("R6 two zeros same cycle", {res, done, early}, 3'b011);
    put(4'b1111, 4'b1111);
    chk("R7 hold after commit", {res, done, early}, 3'b011);
    tick();
    chk("R7 still held", {res, done, early}, 3'b011);
    go();
    chk("R2 restart clears", {res, done, early}, 3'b100);
  endtask

  task automatic t_start_cycle_and_last_zero();
    rep = 4'b0000; vld = 4'b1111; start = 1'b1;
    tick();
    start = 1'b0; vld = '0; rep = '1;
    chk("R2 start-cycle strobes ignored", {res, done, early}, 3'b100);
    tick();
    chk("R2 still open", {res, done, early}, 3'b100);
    put(4'b0111, 4'b0110);
    chk("R8 one zero of three", {res, done, early}, 3'b100);
    put(4'b1000, 4'b0000);
    chk("R3 k-th zero is last arrival", {res, done, early}, 3'b011);
  endtask

  task automatic t_six();
    chk("R1 six reset", {res6, done6, early6}, 3'b100);
    go6();
    put6(6'b001001, 6'b110110);
    put6(6'b011110, 6'b111111);
    chk("R9 five reported", {res6, done6, early6}, 3'b100);
    put6(6'b100000, 6'b111111);
    chk("R9 all six, two zeros", {res6, done6, early6}, 3'b110);
    go6();
    put6(6'b000001, 6'b000000);
    put6(6'b001000, 6'b000000);
    chk("R6 two zeros of three", {res6, done6, early6}, 3'b100);
    put6(6'b100000, 6'b000000);
    chk("R6 zeros across groups", {res6, done6, early6}, 3'b011);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_fast_zero();
    t_all_ones();
    t_stagger_one_zero();
    t_repeat_strobe();
    t_same_cycle_and_hold();
    t_start_cycle_and_last_zero();
    t_six();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule